// File: doc/BRIEF.md
# Serially Programmed Quad Delay Line

This block holds four independent digital delay lines that run on the system clock. Each line takes a single-bit signal and returns a non-inverted copy of it, shifted later in time by a fixed inherent latency of two system clocks plus a programmable step count from 0 to 15. Each line also has an output-enable flag, so its output appears as a data and enable pair that a pad can use to tri-state the pin.

The per-line step counts and enables are set through a three-wire serial port. A serial clock shifts one data bit per rising edge into a 20-bit shift register. A rising edge on a separate latch strobe then copies that register into the holding latch that drives the lines. Until that strobe arrives, the lines keep their previous settings. The serial output always shows the oldest bit in the shift register. Several blocks can therefore be chained, each one's serial output feeding the next one's serial input, while the serial clock and the latch strobe are shared.

The three serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its edges are found in the system clock domain. Each serial level must therefore stay stable for at least three system clocks around every serial clock edge. The signal inputs are taken to be synchronous to the system clock.

Top module: `quad_tap_delay`

## Requirements
- R1: Each rising edge of the serial clock shifts exactly one bit into the 20-bit shift register. The first bit sent ends up as word bit 1 once twenty bits have been shifted. No other activity changes the shift register.
- R2: A rising edge of the latch strobe copies the whole shift register into the holding latch.
- R3: Word bits 1, 2, 3 and 4 enable lines 4, 3, 2 and 1 respectively. An enable of 1 drives that line's `sig_oe_o` bit high. An enable of 0 drives it low, which is the high-impedance request.
- R4: Word bits 5–8 hold the step count of line 1, bits 9–12 line 2, bits 13–16 line 3 and bits 17–20 line 4. Each field arrives most-significant bit first.
- R5: A line whose step count is A reproduces its input on `sig_o` exactly 2 + A system clocks later. Step count 0 gives the minimum delay of 2 clocks, and 15 gives 17 clocks.
- R6: Rising and falling edges are delayed by the same amount, so an input pulse of W clocks appears as an output pulse of W clocks. The output is never inverted.
- R7: `ser_out_o` equals the oldest bit in the shift register. Before the k-th shift of a new word it shows bit k of the previous word.
- R8: Shifting without a strobe leaves the enables and delays in use unchanged. The new values apply only after the strobe.
- R9: After reset, the holding latch and the shift register are all zeros. All four enables are low, every step count is 0, and `ser_out_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one delay step is one period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data in (asynchronous) |
| ser_lat_i | input | 1 | Latch strobe; rising edge loads the settings (asynchronous) |
| ser_out_o | output | 1 | Oldest shift-register bit, for chaining |
| sig_i | input | 4 | Signal inputs, bit n is line n+1 |
| sig_o | output | 4 | Delayed signal outputs, bit n is line n+1 |
| sig_oe_o | output | 4 | Output enables, bit n is line n+1 |

## Verification
All four lines receive the same pulse at once, each set to a different step count: 0, 5, 10 and 15, then 15, 1, 3 and 7, then 8, 0, 15 and 2. The exact cycle of each output edge therefore shows which serial field reached which line. The counts 1 and 8 also separate most-significant-first order from the reverse. Pulses of width 1 to 4 show whether the trailing edge is delayed the same as the leading edge. A pulse sent after a new word has been shifted in, but before the strobe, shows whether the old settings are still in use. The serial output is compared bit by bit against the previous word while the next word is shifted in.

// File: rtl/qdl_pkg.sv
package qdl_pkg;
    parameter int unsigned QDL_LINES  = 4;
    parameter int unsigned QDL_ADDR_W = 4;

    // Bit index (0 = last shifted) of the enable for line g; first-sent bits hold the enables, highest line first.
    function automatic int unsigned qdl_en_pos(int unsigned g, int unsigned lines, int unsigned addr_w);
        return lines * addr_w + g;
    endfunction

    // Low bit index of line g's step field; line 1's field follows the enables.
    function automatic int unsigned qdl_addr_lo(int unsigned g, int unsigned lines, int unsigned addr_w);
        return (lines - 1 - g) * addr_w;
    endfunction
endpackage

// File: rtl/qdl_sync.sv
module qdl_sync #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = raw_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign lvl_o = sy_q.s2;
endmodule

// File: rtl/qdl_cfg_shift.sv
module qdl_cfg_shift #(
    parameter int unsigned WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              lat_i,
    output logic [WORD_W-1:0] word_o,
    output logic              so_o
);
    typedef struct packed {
        logic              sck_prev;
        logic              lat_prev;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] hold;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    shift_en;
    logic    latch_en;

    always_comb begin
        shift_en     = sck_i & ~st_q.sck_prev;
        latch_en     = lat_i & ~st_q.lat_prev;
        st_d          = st_q;
        st_d.sck_prev = sck_i;
        st_d.lat_prev = lat_i;
        if (shift_en) st_d.sh   = {st_q.sh[WORD_W-2:0], sdi_i};
        if (latch_en) st_d.hold = st_q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.hold;
    assign so_o   = st_q.sh[WORD_W-1];

    AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.sh)); // R1
    AST_LATCH_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> (word_o == $past(st_q.sh))); // R2
    AST_SO_NEXT_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (so_o == $past(st_q.sh[WORD_W-2]))); // R7
    AST_HOLD_UNTIL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(word_o)); // R8
endmodule

// File: rtl/qdl_tap_line.sv
module qdl_tap_line #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_i,
    input  logic [ADDR_W-1:0] sel_i,
    output logic              dly_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0] stg;
        logic             out;
    } tap_st_t;

    tap_st_t tp_d, tp_q;

    always_comb begin
        tp_d     = tp_q;
        tp_d.stg = {tp_q.stg[DEPTH-2:0], sig_i};
        tp_d.out = tp_q.stg[sel_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign dly_o = tp_q.out;

    logic warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    AST_INHERENT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q && (sel_i == '0)) |=> (dly_o == $past(sig_i, 2))); // R5
endmodule

// File: rtl/quad_tap_delay.sv
module quad_tap_delay
    import qdl_pkg::*;
#(
    parameter int unsigned LINES  = QDL_LINES,
    parameter int unsigned ADDR_W = QDL_ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_lat_i,
    output logic             ser_out_o,
    input  logic [LINES-1:0] sig_i,
    output logic [LINES-1:0] sig_o,
    output logic [LINES-1:0] sig_oe_o
);
    localparam int unsigned WORD_W = LINES * (ADDR_W + 1);

    logic [2:0]        ser_lvl;
    logic [WORD_W-1:0] cfg_word;

    qdl_sync #(.WIDTH(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({ser_lat_i, ser_clk_i, ser_dat_i}),
        .lvl_o (ser_lvl)
    );

    qdl_cfg_shift #(.WORD_W(WORD_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (ser_lvl[1]),
        .sdi_i  (ser_lvl[0]),
        .lat_i  (ser_lvl[2]),
        .word_o (cfg_word),
        .so_o   (ser_out_o)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam int unsigned EN_POS  = qdl_en_pos(g, LINES, ADDR_W);
        localparam int unsigned ADDR_LO = qdl_addr_lo(g, LINES, ADDR_W);

        qdl_tap_line #(.ADDR_W(ADDR_W)) u_tap (
            .clk   (clk),
            .rst_n (rst_n),
            .sig_i (sig_i[g]),
            .sel_i (cfg_word[ADDR_LO +: ADDR_W]),
            .dly_o (sig_o[g])
        );

        assign sig_oe_o[g] = cfg_word[EN_POS];
    end
endmodule

// File: tb/quad_tap_delay_tb.sv
`timescale 1ns/1ps
module quad_tap_delay_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       lat = 1'b0;
    logic [3:0] sig_in = 4'h0;
    logic       so;
    logic [3:0] sig_out;
    logic [3:0] oe;

    always #2 clk = ~clk;

    quad_tap_delay u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (sck),
        .ser_dat_i (sdi),
        .ser_lat_i (lat),
        .ser_out_o (so),
        .sig_i     (sig_in),
        .sig_o     (sig_out),
        .sig_oe_o  (oe)
    );

    logic [31:0] cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] due;
        logic [1:0]  line;
        logic        val;
        logic        is_w;
    } exp_t;
    exp_t sbq[$];

    // Monitor: compares due items against the delayed outputs (R5 timing, R6 width)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sbq.size() - 1; i >= 0; i--) begin
                if (sbq[i].due == cyc) begin
                    chk(sbq[i].is_w ? "R6 trailing edge" : "R5 leading edge",
                        {31'd0, sig_out[sbq[i].line]}, {31'd0, sbq[i].val});
                    sbq.delete(i);
                end else if (sbq[i].due < cyc) begin
                    chk("R5 item missed", 32'd1, 32'd0);
                    sbq.delete(i);
                end
            end
        end
    end

    // Word layout per R3/R4: bit1..4 = enables of lines 4..1, then line 1..4 fields MSB first
    function automatic logic [19:0] mkw(input logic [3:0] en, input logic [3:0] a1,
                                        input logic [3:0] a2, input logic [3:0] a3,
                                        input logic [3:0] a4);
        return {en[3], en[2], en[1], en[0], a1, a2, a3, a4};
    endfunction

    task automatic send_word(input logic [19:0] w, input logic [19:0] prev);
        for (int k = 19; k >= 0; k--) begin
            @(negedge clk); sdi = w[k];
            repeat (3) @(negedge clk);
            chk("R7 serial out oldest bit", {31'd0, so}, {31'd0, prev[k]});
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic strobe();
        @(negedge clk); lat = 1'b1;
        repeat (4) @(negedge clk);
        lat = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Driver: pulse all lines at once, push expected edges for the given step counts
    task automatic pulse(input logic [3:0] a1, input logic [3:0] a2, input logic [3:0] a3,
                         input logic [3:0] a4, input int w);
        logic [31:0] p;
        logic [3:0]  a [4];
        a[0] = a1; a[1] = a2; a[2] = a3; a[3] = a4;
        @(negedge clk);
        p = cyc;
        sig_in = 4'hF;
        for (int l = 0; l < 4; l++) begin
            sbq.push_back('{due: p + 1 + a[l],     line: 2'(l), val: 1'b0, is_w: 1'b0});
            sbq.push_back('{due: p + 2 + a[l],     line: 2'(l), val: 1'b1, is_w: 1'b0});
            sbq.push_back('{due: p + 1 + a[l] + w, line: 2'(l), val: 1'b1, is_w: 1'b1});
            sbq.push_back('{due: p + 2 + a[l] + w, line: 2'(l), val: 1'b0, is_w: 1'b1});
        end
        repeat (w) @(negedge clk);
        sig_in = 4'h0;
        repeat (24) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        logic [19:0] wa, wb, wc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 enables after reset", {28'd0, oe}, 32'h0);
        chk("R9 serial out after reset", {31'd0, so}, 32'h0);
        pulse(4'd0, 4'd0, 4'd0, 4'd0, 3);              // R9: all step counts 0

        wa = mkw(4'hF, 4'd0, 4'd5, 4'd10, 4'd15);
        send_word(wa, 20'h0);                           // R1, R7
        chk("R8 enables before strobe", {28'd0, oe}, 32'h0);
        pulse(4'd0, 4'd0, 4'd0, 4'd0, 2);              // R8: old counts still used
        strobe();                                       // R2
        chk("R3 all lines enabled", {28'd0, oe}, 32'hF);
        pulse(4'd0, 4'd5, 4'd10, 4'd15, 3);            // R4, R5, R6

        wb = mkw(4'b0101, 4'd15, 4'd1, 4'd3, 4'd7);
        send_word(wb, wa);                              // R7 previous word out
        chk("R8 enables held until strobe", {28'd0, oe}, 32'hF);
        pulse(4'd0, 4'd5, 4'd10, 4'd15, 1);            // R8
        strobe();
        chk("R3 lines 1 and 3 enabled", {28'd0, oe}, 32'h5);
        pulse(4'd15, 4'd1, 4'd3, 4'd7, 4);             // R4 MSB first, R5 maximum

        strobe();                                       // R2: relatch same word
        chk("R2 relatch same word", {28'd0, oe}, 32'h5);

        wc = mkw(4'b1010, 4'd8, 4'd0, 4'd15, 4'd2);
        send_word(wc, wb);
        strobe();
        chk("R3 lines 2 and 4 enabled", {28'd0, oe}, 32'hA);
        chk("R1 word bit 1 reaches serial out", {31'd0, so}, {31'd0, wc[19]});
        pulse(4'd8, 4'd0, 4'd15, 4'd2, 2);

        repeat (4) @(negedge clk);
        chk("R5 scoreboard drained", sbq.size(), 32'd0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule